// File: doc/BRIEF.md
# Input Clock Frequency Band Detector

This block chooses the feedback divide setting for a clock-multiplying PLL. The setting comes from two three-level strap pins. Each pin is already decoded into a 2-bit level code before it reaches the block. Five strap combinations force one of five input bands directly. Some combinations are reserved and give no valid band. When both straps sit at the middle level, the block works out the band itself by measuring the input clock.

In measured mode, a Gray-coded counter runs on the input clock. A free-running measurement clock samples that counter through a two-flop synchronizer. Over each window of 2^WIN_LOG2 measurement cycles, the block takes the difference between samples. That edge count is compared against a lower and an upper bound for each band. A new result, band or no-band, reaches the outputs only when two windows in a row classify the same way, so a frequency change never makes the divider hop through intermediate values. The outputs are a band index, a feedback multiplier (given in half steps) and a valid flag, all registered on the measurement clock.

Top module: `fbd_band_detect`

## Requirements
- R1: With strap code 00 = low, 01 = mid, 10 = high (strap_a first, strap_b second), the pairs high/high, high/low, mid/high, mid/low and low/high select band 0, 1, 2, 3 and 4 respectively, with band_valid high.
- R2: The pairs high/mid, low/mid and low/low, and any pair in which either strap carries code 11, drive band_valid, band_idx and fb_mult_x2 to zero.
- R3: While band_valid is high, fb_mult_x2 (twice the PLL multiplication factor) is 16, 8, 4, 2 and 1 for band 0, 1, 2, 3 and 4 respectively. While band_valid is low, fb_mult_x2 is 0.
- R4: In strap mode, the outputs reflect the strap pair one measurement-clock cycle after the straps are sampled.
- R5: With both straps mid, an input clock whose edge count per 256-cycle window falls within 22..29, 44..58, 88..116, 176..232 or 352..464 is reported as band 0, 1, 2, 3 or 4 respectively. These are the default bounds.
- R6: With both straps mid, an input whose count lies outside every band drives band_valid low.
- R7: A measured result is committed only after two consecutive windows agree. After reset, band_valid stays low for at least two windows. After a frequency step, the reported band changes no sooner than one window later and moves straight from the old band to the new band.
- R8: While rst_n is low, band_valid, band_idx and fb_mult_x2 are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_meas | input | 1 | Free-running measurement clock |
| rst_n | input | 1 | Synchronous active-low reset, shared by both clock domains |
| clk_in | input | 1 | Input clock whose frequency is classified |
| strap_a | input | 2 | First strap level code |
| strap_b | input | 2 | Second strap level code |
| band_valid | output | 1 | A valid band is selected |
| band_idx | output | 3 | Selected band, 0 = lowest frequency |
| fb_mult_x2 | output | 5 | Twice the feedback multiplication factor |

## Verification
The assertions assume two things. First, the straps hold steady for at least one measurement cycle before their effect is checked. Second, reset is held long enough for both clock domains to see it. The bench changes straps only on the falling measurement edge, keeps each pair for several cycles, and holds reset for many cycles while the input clock runs. The hold-time check on measured results applies only after the mid/mid pair has been present for two cycles, because the transition from strap mode to measured mode may legitimately change the outputs at once.

// File: rtl/fbd_pkg.sv
// Shared types and constants for the input clock band detector.
package fbd_pkg;
    localparam int NUM_BANDS = 5;
    localparam int BAND_W    = 3;
    localparam int MULT_W    = 5;

    typedef enum logic [1:0] {
        LVL_LO  = 2'b00,
        LVL_MID = 2'b01,
        LVL_HI  = 2'b10,
        LVL_BAD = 2'b11
    } strap_lvl_e;

    // Classification of one window: hit flag plus band number.
    typedef struct packed {
        logic              hit;
        logic [BAND_W-1:0] idx;
    } band_cls_t;

    // Twice the PLL multiplication factor for a band.
    function automatic logic [MULT_W-1:0] band_mult_x2(input logic [BAND_W-1:0] b);
        case (b)
            3'd0:    return 5'd16;
            3'd1:    return 5'd8;
            3'd2:    return 5'd4;
            3'd3:    return 5'd2;
            3'd4:    return 5'd1;
            default: return 5'd0;
        endcase
    endfunction
endpackage

// File: rtl/fbd_gray_cnt.sv
// Free-running Gray-coded edge counter in the input clock domain.
// Assumes rst_n is held across several input clock cycles.
module fbd_gray_cnt #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] gray_o
);
    logic [W-1:0] bin_q;
    logic [W-1:0] bin_nxt;

    assign bin_nxt = bin_q + 1'b1;

    // Advance the binary count and register its Gray image.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bin_q  <= '0;
            gray_o <= '0;
        end else begin
            bin_q  <= bin_nxt;
            gray_o <= bin_nxt ^ (bin_nxt >> 1);
        end
    end
endmodule

// File: rtl/fbd_win_meter.sv
// Synchronizes the Gray count into the measurement domain and emits the
// edge count of each 2^WIN_LOG2-cycle window with a one-cycle strobe.
// Assumes the count per window stays below 2^W.
module fbd_win_meter #(
    parameter int W        = 12,
    parameter int WIN_LOG2 = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_i,
    output logic [W-1:0] cnt_o,
    output logic         stb_o
);
    logic [W-1:0]        sync1_q, sync2_q;
    logic [W-1:0]        bin_now;
    logic [W-1:0]        bin_prev_q;
    logic [WIN_LOG2-1:0] win_q;

    // Two-flop synchronizer for the Gray count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= '0;
            sync2_q <= '0;
        end else begin
            sync1_q <= gray_i;
            sync2_q <= sync1_q;
        end
    end

    // Gray to binary conversion.
    always_comb begin
        bin_now[W-1] = sync2_q[W-1];
        for (int i = W - 2; i >= 0; i--) begin
            bin_now[i] = bin_now[i+1] ^ sync2_q[i];
        end
    end

    // Window timer and count difference at each window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q      <= '0;
            bin_prev_q <= '0;
            cnt_o      <= '0;
            stb_o      <= 1'b0;
        end else begin
            win_q <= win_q + 1'b1;
            stb_o <= &win_q;
            if (&win_q) begin
                cnt_o      <= bin_now - bin_prev_q;
                bin_prev_q <= bin_now;
            end
        end
    end
endmodule

// File: rtl/fbd_band_class.sv
// Classifies each window count against per-band bounds and commits a
// result only when two consecutive windows agree. Assumes disjoint bands.
module fbd_band_class
    import fbd_pkg::*;
#(
    parameter int                         W      = 12,
    parameter logic [NUM_BANDS*W-1:0]     BAND_LO = '0,
    parameter logic [NUM_BANDS*W-1:0]     BAND_HI = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      cnt_i,
    input  logic              stb_i,
    output logic              valid_o,
    output logic [BAND_W-1:0] idx_o
);
    logic [NUM_BANDS-1:0] hit;
    band_cls_t            cls;
    band_cls_t            prev_q;

    // One range comparator per band.
    for (genvar k = 0; k < NUM_BANDS; k++) begin : g_cmp
        assign hit[k] = (cnt_i >= BAND_LO[k*W +: W]) && (cnt_i <= BAND_HI[k*W +: W]);
    end

    // Pick the lowest matching band.
    always_comb begin
        cls = '0;
        for (int k = NUM_BANDS - 1; k >= 0; k--) begin
            if (hit[k]) begin
                cls.hit = 1'b1;
                cls.idx = BAND_W'(k);
            end
        end
    end

    // Two-window agreement before committing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= '0;
            valid_o <= 1'b0;
            idx_o   <= '0;
        end else if (stb_i) begin
            prev_q <= cls;
            if (cls == prev_q) begin
                valid_o <= cls.hit;
                idx_o   <= cls.hit ? cls.idx : '0;
            end
        end
    end
endmodule

// File: rtl/fbd_band_detect.sv
// Top: decodes the strap pair, or in mid/mid mode uses the measured band,
// and registers band, valid and feedback multiplier on clk_meas.
// Assumes straps are static or change slowly compared with clk_meas.
module fbd_band_detect
    import fbd_pkg::*;
#(
    parameter int                         WIN_LOG2 = 8,
    parameter int                         CNT_W    = 12,
    parameter logic [NUM_BANDS*CNT_W-1:0] BAND_LO  =
        {12'd352, 12'd176, 12'd88, 12'd44, 12'd22},
    parameter logic [NUM_BANDS*CNT_W-1:0] BAND_HI  =
        {12'd464, 12'd232, 12'd116, 12'd58, 12'd29}
) (
    input  logic              clk_meas,
    input  logic              rst_n,
    input  logic              clk_in,
    input  logic [1:0]        strap_a,
    input  logic [1:0]        strap_b,
    output logic              band_valid,
    output logic [BAND_W-1:0] band_idx,
    output logic [MULT_W-1:0] fb_mult_x2
);
    logic [CNT_W-1:0]  gray_cnt;
    logic [CNT_W-1:0]  win_cnt;
    logic              win_stb;
    logic              auto_valid;
    logic [BAND_W-1:0] auto_idx;
    logic              sel_valid;
    logic [BAND_W-1:0] sel_idx;

    fbd_gray_cnt #(.W(CNT_W)) u_gray (
        .clk    (clk_in),
        .rst_n  (rst_n),
        .gray_o (gray_cnt)
    );

    fbd_win_meter #(.W(CNT_W), .WIN_LOG2(WIN_LOG2)) u_meter (
        .clk    (clk_meas),
        .rst_n  (rst_n),
        .gray_i (gray_cnt),
        .cnt_o  (win_cnt),
        .stb_o  (win_stb)
    );

    fbd_band_class #(.W(CNT_W), .BAND_LO(BAND_LO), .BAND_HI(BAND_HI)) u_class (
        .clk     (clk_meas),
        .rst_n   (rst_n),
        .cnt_i   (win_cnt),
        .stb_i   (win_stb),
        .valid_o (auto_valid),
        .idx_o   (auto_idx)
    );

    // Strap pair decode; mid/mid defers to the measured result.
    always_comb begin
        sel_valid = 1'b1;
        sel_idx   = '0;
        case ({strap_a, strap_b})
            {LVL_HI,  LVL_HI }: sel_idx = 3'd0;
            {LVL_HI,  LVL_LO }: sel_idx = 3'd1;
            {LVL_MID, LVL_HI }: sel_idx = 3'd2;
            {LVL_MID, LVL_LO }: sel_idx = 3'd3;
            {LVL_LO,  LVL_HI }: sel_idx = 3'd4;
            {LVL_MID, LVL_MID}: begin
                sel_valid = auto_valid;
                sel_idx   = auto_idx;
            end
            default:            sel_valid = 1'b0;
        endcase
    end

    // Output register.
    always_ff @(posedge clk_meas) begin
        if (!rst_n) begin
            band_valid <= 1'b0;
            band_idx   <= '0;
            fb_mult_x2 <= '0;
        end else begin
            band_valid <= sel_valid;
            band_idx   <= sel_valid ? sel_idx : '0;
            fb_mult_x2 <= sel_valid ? band_mult_x2(sel_idx) : '0;
        end
    end
endmodule

// File: rtl/fbd_band_detect_chk.sv
// Assertion checker for fbd_band_detect, attached through bind.
module fbd_band_detect_chk #(
    parameter int WIN_LOG2 = 8
) (
    input logic       clk_meas,
    input logic       rst_n,
    input logic [1:0] strap_a,
    input logic [1:0] strap_b,
    input logic       band_valid,
    input logic [2:0] band_idx,
    input logic [4:0] fb_mult_x2
);
    localparam int WIN = 1 << WIN_LOG2;

    logic rsv, is_auto, auto_q, auto_qq;
    logic [WIN_LOG2:0] since_chg;

    assign rsv = (strap_a == 2'b11) || (strap_b == 2'b11) ||
                 ({strap_a, strap_b} == 4'b1001) ||
                 ({strap_a, strap_b} == 4'b0001) ||
                 ({strap_a, strap_b} == 4'b0000);
    assign is_auto = (strap_a == 2'b01) && (strap_b == 2'b01);

    // Track how long the outputs have held while the mode stayed measured.
    always_ff @(posedge clk_meas) begin
        if (!rst_n) begin
            auto_q    <= 1'b0;
            auto_qq   <= 1'b0;
            since_chg <= (WIN_LOG2+1)'(WIN);
        end else begin
            auto_q  <= is_auto;
            auto_qq <= auto_q;
            if (!(auto_q && auto_qq))
                since_chg <= (WIN_LOG2+1)'(WIN);
            else if ((band_valid != $past(band_valid)) || (band_idx != $past(band_idx)))
                since_chg <= '0;
            else if (since_chg != (WIN_LOG2+1)'(WIN))
                since_chg <= since_chg + 1'b1;
        end
    end

    // R8: reset clears the outputs
    a_r8_reset_clear: assert property (@(posedge clk_meas)
        !rst_n |=> (!band_valid && band_idx == 3'd0 && fb_mult_x2 == 5'd0));

    a_r2_reserved: assert property (@(posedge clk_meas) disable iff (!rst_n)
        ($past(rst_n) && $past(rsv)) |-> (!band_valid && band_idx == 3'd0));

    a_r1_hh_band0: assert property (@(posedge clk_meas) disable iff (!rst_n)
        ($past(rst_n) && $past(strap_a) == 2'b10 && $past(strap_b) == 2'b10)
        |-> (band_valid && band_idx == 3'd0));

    a_r1_lh_band4: assert property (@(posedge clk_meas) disable iff (!rst_n)
        ($past(rst_n) && $past(strap_a) == 2'b00 && $past(strap_b) == 2'b10)
        |-> (band_valid && band_idx == 3'd4));

    a_r3_mult_valid: assert property (@(posedge clk_meas) disable iff (!rst_n)
        band_valid |-> (fb_mult_x2 == (5'd16 >> band_idx)));

    a_r3_mult_idle: assert property (@(posedge clk_meas) disable iff (!rst_n)
        !band_valid |-> (fb_mult_x2 == 5'd0));

    a_r7_hold_window: assert property (@(posedge clk_meas) disable iff (!rst_n)
        (auto_q && auto_qq && $past(rst_n) &&
         ((band_valid != $past(band_valid)) || (band_idx != $past(band_idx))))
        |-> (since_chg >= (WIN_LOG2+1)'(WIN - 1)));
endmodule

bind fbd_band_detect fbd_band_detect_chk #(.WIN_LOG2(WIN_LOG2)) u_chk (
    .clk_meas   (clk_meas),
    .rst_n      (rst_n),
    .strap_a    (strap_a),
    .strap_b    (strap_b),
    .band_valid (band_valid),
    .band_idx   (band_idx),
    .fb_mult_x2 (fb_mult_x2)
);

// File: tb/fbd_band_detect_tb_top.sv
`timescale 1ns/1ps
module fbd_band_detect_tb_top;
    logic       clk_meas = 1'b0;
    logic       clk_in   = 1'b0;
    logic       rst_n    = 1'b0;
    logic [1:0] strap_a  = 2'b00;
    logic [1:0] strap_b  = 2'b00;
    logic       band_valid;
    logic [2:0] band_idx;
    logic [4:0] fb_mult_x2;
    realtime    in_half = 25.6;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done  = 1'b0;

    always #2.5 clk_meas = ~clk_meas;
    always #(in_half) clk_in = ~clk_in;

    fbd_band_detect dut_i (
        .clk_meas   (clk_meas),
        .rst_n      (rst_n),
        .clk_in     (clk_in),
        .strap_a    (strap_a),
        .strap_b    (strap_b),
        .band_valid (band_valid),
        .band_idx   (band_idx),
        .fb_mult_x2 (fb_mult_x2)
    );

    // {strap_a, strap_b, valid, band, mult}
    localparam int NV = 15;
    localparam logic [12:0] VEC [NV] = '{
        {4'b1010, 1'b1, 3'd0, 5'd16},
        {4'b1000, 1'b1, 3'd1, 5'd8},
        {4'b0110, 1'b1, 3'd2, 5'd4},
        {4'b0100, 1'b1, 3'd3, 5'd2},
        {4'b0010, 1'b1, 3'd4, 5'd1},
        {4'b1001, 1'b0, 3'd0, 5'd0},
        {4'b0001, 1'b0, 3'd0, 5'd0},
        {4'b0000, 1'b0, 3'd0, 5'd0},
        {4'b0011, 1'b0, 3'd0, 5'd0},
        {4'b0111, 1'b0, 3'd0, 5'd0},
        {4'b1011, 1'b0, 3'd0, 5'd0},
        {4'b1100, 1'b0, 3'd0, 5'd0},
        {4'b1101, 1'b0, 3'd0, 5'd0},
        {4'b1110, 1'b0, 3'd0, 5'd0},
        {4'b1111, 1'b0, 3'd0, 5'd0}
    };

    task automatic check(input string req, input logic v, input logic [2:0] b, input logic [4:0] m);
        n_chk++;
        if (band_valid !== v || band_idx !== b || fb_mult_x2 !== m) begin
            n_bad++;
            $display("FAIL %s: got valid=%0b band=%0d mult=%0d, expected valid=%0b band=%0d mult=%0d",
                     req, band_valid, band_idx, fb_mult_x2, v, b, m);
        end
    endtask

    task automatic wait_meas(input int n);
        for (int i = 0; i < n; i++) @(negedge clk_meas);
    endtask

    // Measured-mode check after settling four windows.
    task automatic auto_case(input realtime half, input string req, input logic v, input logic [2:0] b, input logic [4:0] m);
        in_half = half;
        wait_meas(1100);
        check(req, v, b, m);
    endtask

    initial begin
        int first_new;
        bit path_ok;
        wait_meas(20);
        // R8: reset state
        check("R8", 1'b0, 3'd0, 5'd0);
        rst_n = 1'b1;

        // R1 R2 R3 R4: strap table
        for (int i = 0; i < NV; i++) begin
            {strap_a, strap_b} = VEC[i][12:9];
            wait_meas(2);
            check(VEC[i][8] ? "R1/R3/R4" : "R2/R3", VEC[i][8], VEC[i][7:5], VEC[i][4:0]);
        end
        // R4: one cycle of latency after a strap change
        {strap_a, strap_b} = 4'b1010;
        wait_meas(3);
        {strap_a, strap_b} = 4'b0010;
        @(posedge clk_meas); #1;
        check("R4 latency", 1'b1, 3'd4, 5'd1);

        // R5 R6: measured mode across every band and one gap
        {strap_a, strap_b} = 4'b0101;
        auto_case(25.6, "R5 band0", 1'b1, 3'd0, 5'd16);
        auto_case(12.8, "R5 band1", 1'b1, 3'd1, 5'd8);
        auto_case(6.4,  "R5 band2", 1'b1, 3'd2, 5'd4);
        auto_case(3.2,  "R5 band3", 1'b1, 3'd3, 5'd2);
        auto_case(1.6,  "R5 band4", 1'b1, 3'd4, 5'd1);
        auto_case(16.0, "R6 gap",   1'b0, 3'd0, 5'd0);
        auto_case(0.8,  "R6 above", 1'b0, 3'd0, 5'd0);
        auto_case(6.4,  "R5 band2 again", 1'b1, 3'd2, 5'd4);

        // R7: step to band 3, the band must jump directly and not too early
        in_half = 3.2;
        first_new = -1;
        path_ok = 1'b1;
        for (int c = 0; c < 1200; c++) begin
            @(negedge clk_meas);
            if (!band_valid || (band_idx != 3'd2 && band_idx != 3'd3)) path_ok = 1'b0;
            if (first_new < 0 && band_idx == 3'd3) first_new = c;
        end
        n_chk++;
        if (!path_ok) begin
            n_bad++;
            $display("FAIL R7 path: got intermediate output, expected only band 2 then 3");
        end
        n_chk++;
        if (first_new < 255) begin
            n_bad++;
            $display("FAIL R7 latency: got switch after %0d cycles, expected >= 255", first_new);
        end
        check("R7 final", 1'b1, 3'd3, 5'd2);

        // R7 R8: reset in measured mode, valid stays low for two windows
        rst_n = 1'b0;
        wait_meas(10);
        check("R8 reset auto", 1'b0, 3'd0, 5'd0);
        rst_n = 1'b1;
        path_ok = 1'b1;
        for (int c = 0; c < 500; c++) begin
            @(negedge clk_meas);
            if (band_valid) path_ok = 1'b0;
        end
        n_chk++;
        if (!path_ok) begin
            n_bad++;
            $display("FAIL R7 startup: got valid=1 within two windows, expected 0");
        end
        wait_meas(600);
        check("R7 startup commit", 1'b1, 3'd3, 5'd2);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                for (int i = 0; i < 150000; i++) @(posedge clk_meas);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: got timeout, expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule